// File: doc/BRIEF.md
# Boolean Logic Unit with Status Flags

This block performs bitwise boolean work on a destination operand and a source operand. It also holds a small status-flag register that every operation updates under its own rule. The supported operations are AND, OR, XOR, a flag-only AND probe (TEST), a one's-complement inversion (NOT), and three operations that act directly on the carry flag: clear, set and invert.

Each request is presented for one cycle with `in_valid` high. One clock later the block shows the outcome on its registered outputs:

- `out_valid` pulses high for that cycle.
- `dst_wr_en` says whether the destination should be written back.
- `dst_result` carries the computed value.
- `flags_q` shows the flag register after the update.

The operand width is a parameter with a default of 32 bits and must be at least 8. The auxiliary-carry flag is always driven to 0 by the logic operations, so every result is deterministic.

Top module: `bool_logic_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R2: Opcodes 0 (AND), 1 (OR) and 2 (XOR) register `dst_value` AND/OR/XOR `src_value` on `dst_result` with `dst_wr_en` high. XOR of equal operands gives zero.
- R3: After opcodes 0, 1, 2 or 3, three flags are set from the result:
  - flag bit 4 (sign) equals the result's most significant bit;
  - flag bit 3 (zero) is 1 exactly when the result is all zeros;
  - flag bit 1 (parity) is 1 when the result's low byte has an even number of ones.
- R4: After opcodes 0, 1, 2 or 3, flag bits 5 (overflow), 0 (carry) and 2 (auxiliary carry) are all 0.
- R5: Opcode 3 (TEST) puts the AND of the operands on `dst_result` and updates the flags exactly as AND does, but leaves `dst_wr_en` low.
- R6: Opcode 4 (NOT) registers the bitwise inverse of `dst_value` with `dst_wr_en` high and leaves all six flags unchanged. XOR with an all-ones source gives the same data but also updates the flags.
- R7: The carry opcodes behave as follows:
  - opcode 5 sets flag bit 0 to 0;
  - opcode 6 sets flag bit 0 to 1;
  - opcode 7 inverts flag bit 0.
  
  In each case flag bits 5 to 1 are unchanged, `dst_wr_en` is low and `dst_result` equals `dst_value`.
- R8: While `rst_n` is low, `out_valid`, `dst_wr_en`, `dst_result` and `flags_q` are all zero.
- R9: In a cycle after one without `in_valid`, `flags_q` keeps its value and `dst_wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one operation per high cycle |
| op_code | input | 3 | Operation select, encodings as in R2, R5, R6 and R7 |
| dst_value | input | W | Destination operand |
| src_value | input | W | Source operand |
| out_valid | output | 1 | One-cycle pulse marking a completed operation |
| dst_wr_en | output | 1 | Write-back request for the destination |
| dst_result | output | W | Registered operation result |
| flags_q | output | 6 | Flag register: bit5 overflow, bit4 sign, bit3 zero, bit2 auxiliary carry, bit1 parity, bit0 carry |

## Verification
The flag register is the only state that outlives a request, so a corrupted flag bit stays hidden until something reads it. A bad sign, zero or parity bit is overwritten by the next logic operation. It is seen at the ports immediately only when the following operation is NOT, a carry operation or an idle cycle, all of which must keep it. A bad carry bit shows up as soon as a carry-invert runs.

The bench therefore interleaves carry operations and NOT between logic operations. It also compares the whole flag vector after every response, so any stale or cross-coupled bit shows within one cycle of the operation that exposes it.

// File: rtl/blu_pkg.sv
package blu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_TEST = 3'd3,
    OP_NOT  = 3'd4,
    OP_CCLR = 3'd5,
    OP_CSET = 3'd6,
    OP_CINV = 3'd7
  } blu_op_e;

  // packed: first member is the most significant bit
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } blu_flags_t;

  localparam int unsigned FLAG_BITS = 6;

  function automatic logic op_is_logic(input blu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
  endfunction

  function automatic logic op_is_carry(input blu_op_e op);
    return (op == OP_CCLR) || (op == OP_CSET) || (op == OP_CINV);
  endfunction

  function automatic logic op_writes_back(input blu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
  endfunction

  // 1 when the byte holds an even count of ones
  function automatic logic byte_parity_even(input logic [7:0] b);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < 8; i++) acc = acc ^ b[i];
    return acc;
  endfunction

  function automatic logic next_carry(input blu_op_e op, input logic cur);
    case (op)
      OP_CCLR: return 1'b0;
      OP_CSET: return 1'b1;
      OP_CINV: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/blu_datapath.sv
module blu_datapath
  import blu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  blu_op_e        op,
  input  logic [W-1:0]   dst,
  input  logic [W-1:0]   src,
  output logic [W-1:0]   res,
  output logic           wr_req
);

  logic [W-1:0] and_v;
  logic [W-1:0] or_v;
  logic [W-1:0] xor_v;
  logic [W-1:0] inv_v;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_v[i] = dst[i] & src[i];
    assign or_v[i]  = dst[i] | src[i];
    assign xor_v[i] = dst[i] ^ src[i];
    assign inv_v[i] = ~dst[i];
  end

  always_comb begin
    case (op)
      OP_AND, OP_TEST: res = and_v;
      OP_OR:           res = or_v;
      OP_XOR:          res = xor_v;
      OP_NOT:          res = inv_v;
      default:         res = dst;
    endcase
  end

  assign wr_req = op_writes_back(op);

endmodule

// File: rtl/blu_flag_unit.sv
module blu_flag_unit
  import blu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  blu_op_e       op,
  input  logic [W-1:0]  res,
  output blu_flags_t    flags
);

  localparam logic [W-1:0] ALL_ZERO = '0;

  blu_flags_t nxt;
  logic       logic_upd;
  logic       carry_upd;
  logic       res_is_zero;

  assign logic_upd   = fire && op_is_logic(op);
  assign carry_upd   = fire && op_is_carry(op);
  assign res_is_zero = (res == ALL_ZERO);

  always_comb begin
    nxt = flags;
    if (logic_upd) begin
      nxt.sgn = res[W-1];
      nxt.zro = res_is_zero;
      nxt.par = byte_parity_even(res[7:0]);
      nxt.ovf = 1'b0;
      nxt.cry = 1'b0;
      nxt.aux = 1'b0;
    end else if (carry_upd) begin
      nxt.cry = next_carry(op, flags.cry);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  AST_LOGIC_CLEARS_OC: assert property (@(posedge clk) disable iff (!rst_n)
    logic_upd |=> (!flags.ovf && !flags.cry && !flags.aux)); // R4

  AST_CARRY_ONLY_CF: assert property (@(posedge clk) disable iff (!rst_n)
    carry_upd |=> (flags.ovf == $past(flags.ovf) && flags.sgn == $past(flags.sgn)
                   && flags.zro == $past(flags.zro) && flags.par == $past(flags.par))); // R7

endmodule

// File: rtl/blu_out_stage.sv
module blu_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          wr_req,
  input  logic [W-1:0]  res,
  output logic          valid_q,
  output logic          wr_q,
  output logic [W-1:0]  res_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= fire;
      wr_q    <= fire && wr_req;
      if (fire) res_q <= res;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> valid_q); // R1

  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (!valid_q && !wr_q)); // R1

endmodule

// File: rtl/bool_logic_unit.sv
module bool_logic_unit
  import blu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op_code,
  input  logic [W-1:0]  dst_value,
  input  logic [W-1:0]  src_value,
  output logic          out_valid,
  output logic          dst_wr_en,
  output logic [W-1:0]  dst_result,
  output logic [5:0]    flags_q
);

  blu_op_e      op;
  logic [W-1:0] dp_res;
  logic         dp_wr;
  blu_flags_t   flag_reg;
  logic         req_test;
  logic         req_not;
  logic         req_self_xor;

  assign op           = blu_op_e'(op_code);
  assign req_test     = in_valid && (op == OP_TEST);
  assign req_not      = in_valid && (op == OP_NOT);
  assign req_self_xor = in_valid && (op == OP_XOR) && (dst_value == src_value);

  blu_datapath #(.W(W)) u_dp (
    .op     (op),
    .dst    (dst_value),
    .src    (src_value),
    .res    (dp_res),
    .wr_req (dp_wr)
  );

  blu_flag_unit #(.W(W)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (in_valid),
    .op    (op),
    .res   (dp_res),
    .flags (flag_reg)
  );

  blu_out_stage #(.W(W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (in_valid),
    .wr_req  (dp_wr),
    .res     (dp_res),
    .valid_q (out_valid),
    .wr_q    (dst_wr_en),
    .res_q   (dst_result)
  );

  assign flags_q = flag_reg;

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_test |=> (out_valid && !dst_wr_en)); // R5

  AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    req_not |=> $stable(flags_q)); // R6

  AST_SELF_XOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_self_xor |=> (flags_q[3] && dst_result == '0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(flags_q)); // R9

endmodule

// File: tb/bool_logic_unit_tb_top.sv
module bool_logic_unit_tb_top;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [TW-1:0] dst_value = '0;
  logic [TW-1:0] src_value = '0;
  logic          out_valid;
  logic          dst_wr_en;
  logic [TW-1:0] dst_result;
  logic [5:0]    flags_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic [5:0] mflags = '0;

  always #5 clk = ~clk;

  bool_logic_unit #(.W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .dst_value(dst_value), .src_value(src_value), .out_valid(out_valid),
    .dst_wr_en(dst_wr_en), .dst_result(dst_result), .flags_q(flags_q)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic even_low_byte(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v / (1 << i)) % 2;
    return (c % 2) == 0;
  endfunction

  // expected model, written from the requirements
  task automatic run_op(input int op, input int d, input int s);
    int r;
    logic wr;
    int lim = 1 << TW;
    string tag;
    case (op)
      0: r = d & s;
      1: r = d | s;
      2: r = d ^ s;
      3: r = d & s;
      4: r = (lim - 1) - d;
      default: r = d;
    endcase
    wr = (op <= 2) || (op == 4);
    if (op <= 3) begin
      mflags[4] = (r >= lim / 2);
      mflags[3] = (r == 0);
      mflags[1] = even_low_byte(r);
      mflags[5] = 1'b0;
      mflags[0] = 1'b0;
      mflags[2] = 1'b0;
    end else if (op == 5) mflags[0] = 1'b0;
    else if (op == 6) mflags[0] = 1'b1;
    else if (op == 7) mflags[0] = ~mflags[0];
    tag = (op <= 2) ? "R2/R3/R4" : (op == 3) ? "R5/R3/R4" : (op == 4) ? "R6" : "R7";
    in_valid = 1'b1; op_code = op[2:0]; dst_value = d[TW-1:0]; src_value = s[TW-1:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R1 out_valid", int'(out_valid), 1);
    chk(dst_wr_en === wr, {tag, " wr_en"}, int'(dst_wr_en), int'(wr));
    chk(dst_result === r[TW-1:0], {tag, " result"}, int'(dst_result), r);
    chk(flags_q === mflags, {tag, " flags"}, int'(flags_q), int'(mflags));
  endtask

  task automatic idle_check(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R1 idle out_valid", int'(out_valid), 0);
      chk(dst_wr_en === 1'b0, "R9 idle wr_en", int'(dst_wr_en), 0);
      chk(flags_q === mflags, "R9 idle flags", int'(flags_q), int'(mflags));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int svals[10] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h7F, 8'hFE};
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(out_valid === 1'b0, "R8 out_valid", int'(out_valid), 0);
    chk(dst_wr_en === 1'b0, "R8 wr_en", int'(dst_wr_en), 0);
    chk(dst_result === '0, "R8 result", int'(dst_result), 0);
    chk(flags_q === 6'd0, "R8 flags", int'(flags_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check(2);

    // R7 carry ops on a known flag state
    run_op(0, 8'h81, 8'h81);   // sign set, parity even
    run_op(6, 8'h12, 0);
    run_op(7, 8'h34, 0);
    run_op(7, 8'h56, 0);
    run_op(5, 8'h78, 0);
    run_op(6, 8'h9A, 0);
    idle_check(3);            // R9 carry must persist
    run_op(4, 8'h3C, 0);      // R6 NOT keeps CF=1 and others
    run_op(2, 8'hC3, 8'hC3);  // R2 self XOR zero, R4 clears CF
    run_op(6, 8'h00, 0);
    run_op(2, 8'h3C, 8'hFF);  // R6 XOR all-ones vs NOT data

    // near-exhaustive sweep
    for (int d = 0; d < 256; d++) begin
      run_op(((d % 3) == 0) ? 7 : 6, d, 0);
      for (int op = 0; op < 5; op++) begin
        for (int j = 0; j < 10; j++) run_op(op, d, svals[j]);
        run_op(op, d, d);
        run_op(op, d, 255 - d);
        if ((d % 16) == 0) run_op(4, d, d);
      end
    end
    idle_check(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule